// File: doc/BRIEF.md
# Radix-4 Digit-Reversal Address Generator

This block produces the address stream for the reorder copy that follows a radix-4 decimation-in-frequency FFT. That FFT leaves its results in base-4 digit-reversed order. One copy pass moves every point from an input buffer to its natural position in an output buffer. On each transfer the generator offers a source index, which counts up one by one, and a destination index, which is the same value with its base-4 digits in mirror order. The buffers themselves sit outside the block.

A run begins with a `start_i` pulse while the generator is idle. That pulse latches a 2-bit size code, which selects 16, 64, 256 or 1024 points. The generator then sends exactly N index pairs on a valid/ready stream.

- A pair is taken on every cycle in which `valid_o` and `ready_i` are both high.
- While `ready_i` is low, the pair on offer stays unchanged and `valid_o` stays high.
- After the last pair is taken, `done_o` pulses for a single cycle.

The destination is not computed from scratch for each index. The generator keeps three pieces of state and steps them as the source index advances:

- a quarter-offset digit;
- a middle field, updated by a carry that runs from its high digit toward its low digit;
- a subgroup start address (0 to 3), which is incremented by one each time a subgroup is finished.

Top module: `quad_digrev_agen`

## Requirements
- R1: After reset `valid_o` and `done_o` are low, and they stay low while no run has been started, whatever `ready_i` does.
- R2: A `start_i` pulse while idle latches `size_i` as the point count N: code 0 gives 16, 1 gives 64, 2 gives 256 and 3 gives 1024, that is N = 4^(code+2). `valid_o` is high in the next cycle, offering source index 0.
- R3: A run offers exactly N pairs. The source index starts at 0 and increases by one on each accepted pair (`valid_o` and `ready_i` both high).
- R4: Each destination index is the base-4 digit reversal of its source index over log4(N) digits. Each digit is the bit pair [2k+1:2k]. The order of the pairs is mirrored and the bits inside each pair keep their order; for example binary 1011 becomes 1110.
- R5: Source index 1 always maps to N/4. For 16 points, indices 0, 1, 2, 3, 4 map to 0, 4, 8, 12, 1, and index 15 maps to 15.
- R6: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and both indices hold their values.
- R7: `done_o` is high for exactly one cycle: the cycle after the last pair is accepted. In that cycle `valid_o` is low.
- R8: `start_i` and `size_i` have no effect while a run is in progress. The run finishes with the N, the order and the destinations latched at its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; taken only while idle |
| size_i | input | 2 | Point-count code, latched at start |
| ready_i | input | 1 | Consumer accepts the offered pair |
| valid_o | output | 1 | A pair is on offer |
| src_o | output | 10 | Source (sequential) index |
| dst_o | output | 10 | Destination (digit-reversed) index |
| done_o | output | 1 | One-cycle pulse after the last pair |

## Verification
The bench builds the block with its default size-code width of 2. This makes all four point counts reachable, from the two-digit case, which has no middle field, up to the five-digit 1024-point case, whose middle field is three digits wide. Every offered pair is compared with a direct digit reversal, so each carry path of the middle-field counter and each subgroup handover is covered. Random back-pressure and random `start_i`/`size_i` noise during runs check that stalls hold the pair and that a run in progress cannot be restarted.

// File: rtl/digrev_pkg.sv
package digrev_pkg;
  localparam int unsigned DIGIT_BITS = 2;
  localparam int unsigned MIN_DIGITS = 2;

  typedef enum logic [1:0] {
    PTS_16   = 2'd0,
    PTS_64   = 2'd1,
    PTS_256  = 2'd2,
    PTS_1024 = 2'd3
  } pts_code_e;
endpackage

// File: rtl/digrev_cfg.sv
// Latches the size code at start and derives digit counts and last index.
module digrev_cfg #(
  parameter int unsigned CODE_W = 2,
  parameter int unsigned DW     = 3,
  parameter int unsigned AW     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [DW-1:0]     digits_o,
  output logic [DW-1:0]     mid_digits_o,
  output logic [AW-1:0]     last_idx_o
);
  import digrev_pkg::*;

  logic [DW-1:0] digits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digits_q <= DW'(MIN_DIGITS);
    end else if (load_i) begin
      digits_q <= DW'(MIN_DIGITS) + DW'(code_i);
    end
  end

  assign digits_o     = digits_q;
  assign mid_digits_o = digits_q - DW'(MIN_DIGITS);
  assign last_idx_o   = ~({AW{1'b1}} << (2 * digits_q));
endmodule

// File: rtl/digrev_revinc.sv
// Reverse-carry increment of the middle field: the carry enters at the
// highest active digit and ripples toward digit 0.
module digrev_revinc #(
  parameter int unsigned MIDW = 3,
  parameter int unsigned DW   = 3
) (
  input  logic [2*MIDW-1:0] field_i,
  input  logic [DW-1:0]     active_i,
  output logic [2*MIDW-1:0] field_o,
  output logic              wrap_o
);
  always_comb begin
    logic c;
    c       = 1'b0;
    field_o = field_i;
    for (int q = MIDW - 1; q >= 0; q--) begin
      if (q + 1 == int'(active_i)) begin
        c = 1'b1;
      end else if (q + 1 > int'(active_i)) begin
        c = 1'b0;
      end
      field_o[2*q +: 2] = field_i[2*q +: 2] + {1'b0, c};
      c = c & (field_i[2*q +: 2] == 2'd3);
    end
    wrap_o = (active_i == '0) | c;
  end
endmodule

// File: rtl/digrev_dstasm.sv
// Places the subgroup, middle field and quarter digit into the destination.
module digrev_dstasm #(
  parameter int unsigned MAX_DIGITS = 5,
  parameter int unsigned DW         = 3
) (
  input  logic [1:0]                  sub_i,
  input  logic [2*(MAX_DIGITS-2)-1:0] mid_i,
  input  logic [1:0]                  top_i,
  input  logic [DW-1:0]               digits_i,
  output logic [2*MAX_DIGITS-1:0]     dst_o
);
  logic [DW-1:0] top_pos;
  assign top_pos = digits_i - DW'(1);

  for (genvar p = 0; p < MAX_DIGITS; p++) begin : g_digit
    localparam logic [DW-1:0] P = DW'(p);
    if (p == 0) begin : g_low
      assign dst_o[1:0] = sub_i;
    end else if (p <= MAX_DIGITS - 2) begin : g_mid
      assign dst_o[2*p +: 2] = (P == top_pos) ? top_i :
                               (P <  top_pos) ? mid_i[2*(p-1) +: 2] : 2'd0;
    end else begin : g_high
      assign dst_o[2*p +: 2] = (P == top_pos) ? top_i : 2'd0;
    end
  end
endmodule

// File: rtl/quad_digrev_agen.sv
module quad_digrev_agen #(
  parameter int unsigned CODE_W = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start_i,
  input  logic [CODE_W-1:0]                      size_i,
  input  logic                                   ready_i,
  output logic                                   valid_o,
  output logic [2*(2+(2**CODE_W)-1)-1:0]         src_o,
  output logic [2*(2+(2**CODE_W)-1)-1:0]         dst_o,
  output logic                                   done_o
);
  localparam int unsigned MAX_DIGITS = 2 + (2**CODE_W) - 1;
  localparam int unsigned AW         = 2 * MAX_DIGITS;
  localparam int unsigned MIDW       = MAX_DIGITS - 2;
  localparam int unsigned DW         = $clog2(MAX_DIGITS + 1);

  logic              run_q, done_q;
  logic [AW-1:0]     src_q;
  logic [1:0]        top_q, sub_q;
  logic [2*MIDW-1:0] mid_q, mid_next;
  logic              mid_wrap;
  logic [DW-1:0]     digits, mid_digits;
  logic [AW-1:0]     last_idx;
  logic              start_ok, accept, last;

  assign start_ok = start_i & ~run_q;
  assign accept   = run_q & ready_i;
  assign last     = (src_q == last_idx);

  digrev_cfg #(.CODE_W(CODE_W), .DW(DW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .code_i(size_i),
    .digits_o(digits), .mid_digits_o(mid_digits), .last_idx_o(last_idx)
  );

  digrev_revinc #(.MIDW(MIDW), .DW(DW)) u_rev (
    .field_i(mid_q), .active_i(mid_digits), .field_o(mid_next), .wrap_o(mid_wrap)
  );

  digrev_dstasm #(.MAX_DIGITS(MAX_DIGITS), .DW(DW)) u_asm (
    .sub_i(sub_q), .mid_i(mid_q), .top_i(top_q), .digits_i(digits), .dst_o(dst_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      src_q  <= '0;
      top_q  <= '0;
      mid_q  <= '0;
      sub_q  <= '0;
    end else if (start_ok) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      src_q  <= '0;
      top_q  <= '0;
      mid_q  <= '0;
      sub_q  <= '0;
    end else if (accept) begin
      src_q  <= src_q + AW'(1);
      top_q  <= top_q + 2'd1;
      done_q <= last;
      if (last) run_q <= 1'b0;
      if (top_q == 2'd3) begin
        mid_q <= mid_next;
        if (mid_wrap) sub_q <= sub_q + 2'd1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign valid_o = run_q;
  assign src_o   = src_q;
  assign done_o  = done_q;
endmodule

// File: rtl/digrev_chk.sv
module digrev_chk #(
  parameter int unsigned CODE_W = 2,
  parameter int unsigned AW     = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CODE_W-1:0] size_i,
  input logic              ready_i,
  input logic              valid_o,
  input logic [AW-1:0]     src_o,
  input logic [AW-1:0]     dst_o,
  input logic              done_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else if (start_i && !valid_o) code_q <= size_i;
  end

  function automatic logic [AW-1:0] mirror(input logic [AW-1:0] i, input int d);
    logic [AW-1:0] r;
    r = '0;
    for (int k = 0; k < AW / 2; k++) begin
      if (k < d) r[2*(d-1-k) +: 2] = i[2*k +: 2];
    end
    return r;
  endfunction

  a_r2_start_offers: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_o) |=> (valid_o && src_o == '0));

  a_r3_src_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i) |=> (!valid_o || src_o == $past(src_o) + AW'(1)));

  a_r4_dst_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (dst_o == mirror(src_o, int'(code_q) + 2)));

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(src_o) && $stable(dst_o)));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind quad_digrev_agen digrev_chk #(.CODE_W(CODE_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
  .ready_i(ready_i), .valid_o(valid_o), .src_o(src_o), .dst_o(dst_o),
  .done_o(done_o)
);

// File: tb/sim_quad_digrev_agen.sv
module sim_quad_digrev_agen;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    size_i = 2'd0;
  logic          ready_i = 1'b0;
  logic          valid_o, done_o;
  logic [AW-1:0] src_o, dst_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  quad_digrev_agen u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .ready_i(ready_i), .valid_o(valid_o), .src_o(src_o), .dst_o(dst_o),
    .done_o(done_o)
  );

  function automatic int unsigned rev4(int unsigned i, int unsigned d);
    int unsigned r = 0;
    for (int unsigned k = 0; k < d; k++)
      r |= ((i >> (2*k)) & 3) << (2*(d-1-k));
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(int unsigned code, int unsigned pct, bit noisy);
    int unsigned n = 1 << (2*(code+2));
    int unsigned cnt = 0;
    @(negedge clk);
    start_i = 1'b1; size_i = 2'(code); ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o == 1'b1, "R2 valid after start", 32'(valid_o), 1);
    while (cnt < n) begin
      bit r;
      chk(valid_o == 1'b1, "R3 valid during run", 32'(valid_o), 1);
      chk(src_o == AW'(cnt), "R3 src order", 32'(src_o), cnt);
      chk(dst_o == AW'(rev4(cnt, code+2)), "R4 dst reversal", 32'(dst_o), rev4(cnt, code+2));
      if (cnt == 1) chk(dst_o == AW'(n/4), "R5 index 1", 32'(dst_o), n/4);
      if (n == 16 && cnt == 4) chk(dst_o == 1, "R5 index 4", 32'(dst_o), 1);
      if (n == 16 && cnt == 15) chk(dst_o == 15, "R5 index 15", 32'(dst_o), 15);
      r = ($urandom % 100) < pct;
      ready_i = r;
      if (noisy) begin
        start_i = ($urandom % 6) == 0;
        size_i  = 2'($urandom);
      end
      @(negedge clk);
      if (r) cnt++;
      else begin
        chk(valid_o && src_o == AW'(cnt), "R6 stall holds", 32'(src_o), cnt);
      end
    end
    start_i = 1'b0; ready_i = 1'b0;
    chk(done_o == 1'b1, "R7 done after last", 32'(done_o), 1);
    chk(valid_o == 1'b0, "R7 valid low at done", 32'(valid_o), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", 32'(done_o), 0);
    chk(valid_o == 1'b0, "R3 exactly N pairs", 32'(valid_o), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 reset valid", 32'(valid_o), 0);
    chk(done_o == 1'b0, "R1 reset done", 32'(done_o), 0);
    rst_n = 1'b1;
    ready_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(valid_o == 1'b0, "R1 idle valid", 32'(valid_o), 0);
    chk(done_o == 1'b0, "R1 idle done", 32'(done_o), 0);
    run(0, 100, 1'b0);
    run(0, 50, 1'b1);
    run(1, 60, 1'b1);   // R8 noise on start/size
    run(2, 40, 1'b1);
    run(3, 70, 1'b1);
    run(3, 100, 1'b0);
    run(1, 100, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule